// File: doc/BRIEF.md
# Carry-Save Tree Unsigned Multiplier

This block multiplies two unsigned N-bit integers and returns the 2N-bit product. Each operation runs as three registered phases. In the first phase a grid of two-input AND gates forms the N shifted partial-product rows. In the second phase layers of 1-bit full adders compress bits of equal weight, three rows into two, until only a sum row and a carry row remain. In the third phase a ripple adder built from the same full-adder cells adds those two rows.

The caller pulses `start_i` for one cycle with both operands present. Exactly three cycles later `done_o` pulses for one cycle, and `prod_o` then holds the product until the next result replaces it. The block handles one operation at a time. A start request is dropped while the first two phases are busy. A start request is taken in the cycle that `done_o` is high, so operations can follow each other every three cycles.

Top module: `tree_umul`

## Requirements
- R1: When `done_o` is high, `prod_o` equals the unsigned product of the `a_i` and `b_i` values sampled with the accepted start, over the full 2N bits.
- R2: An accepted start at a clock edge makes `done_o` high for exactly one cycle, in the third cycle after that edge. `done_o` is low in the two cycles before it and in the cycle after it, unless another start was accepted.
- R3: A start is accepted only when neither the summand phase nor the reduction phase holds an operation. A start in either of the two cycles after an acceptance is ignored: it produces no extra `done_o` pulse and does not change the pending result. A start in the cycle where `done_o` is high is accepted.
- R4: Row i of the summand array is the multiplicand ANDed with multiplier bit i and shifted left i places. With multiplicand 4'b1001 and multiplier 4'b1010 at N=4, the product is 8'b01011010 (90).
- R5: After reduction, the sum row plus the carry row (the carry already shifted one place up) equals the product modulo 2^(2N).
- R6: `prod_o` keeps its value in every cycle where no new result is completed.
- R7: After reset, `done_o` is 0 and `prod_o` is all zeros.
- R8: The largest operands, (2^N-1) x (2^N-1), give the exact product with no lost bit.
- R9: Operand values in cycles other than the accepting cycle have no effect on the result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; the release is synchronised inside the block |
| start_i | input | 1 | Start pulse that requests a multiply |
| a_i | input | N | Multiplicand, unsigned |
| b_i | input | N | Multiplier, unsigned |
| done_o | output | 1 | One-cycle pulse that marks a valid product |
| prod_o | output | 2N | Product, held until the next result |

## Verification
The bench builds two copies of the block, one at N=4 and one at N=8. The N=4 copy makes every operand pair affordable, so every summand pattern and every carry path of the three-row reduction is exercised. It also carries the worked 1001 x 1010 example. The N=8 copy has a four-layer tree and exercises the directed corners (zero, one, all-ones, single bits), the dropped and back-to-back starts, and a few hundred random pairs.

// File: rtl/tree_umul_pkg.sv
package tree_umul_pkg;

  // Rows left after l compression layers when starting from n rows.
  function automatic int rows_after(input int n, input int l);
    int r;
    r = n;
    for (int k = 0; k < l; k++) r = 2 * (r / 3) + (r % 3);
    return r;
  endfunction

  // Number of 3:2 layers needed to bring n rows down to two.
  function automatic int layer_count(input int n);
    int r;
    int c;
    r = n;
    c = 0;
    while (r > 2) begin
      r = 2 * (r / 3) + (r % 3);
      c++;
    end
    return c;
  endfunction

endpackage

// File: rtl/tree_umul_fa.sv
module tree_umul_fa (
  input  logic a_i,
  input  logic b_i,
  input  logic c_i,
  output logic s_o,
  output logic co_o
);

  logic half;

  assign half = a_i ^ b_i;
  assign s_o  = half ^ c_i;
  assign co_o = (a_i & b_i) | (c_i & half);

endmodule

// File: rtl/tree_umul_pp.sv
module tree_umul_pp #(
  parameter int N = 8
) (
  input  logic [N-1:0]          a_i,
  input  logic [N-1:0]          b_i,
  output logic [N-1:0][2*N-1:0] rows_o
);

  localparam int W = 2 * N;

  for (genvar i = 0; i < N; i++) begin : g_row
    logic [N-1:0] gated;
    assign gated     = a_i & {N{b_i[i]}};
    assign rows_o[i] = {{N{1'b0}}, gated} << i;
  end

endmodule

// File: rtl/tree_umul_csa.sv
module tree_umul_csa
  import tree_umul_pkg::*;
#(
  parameter int N = 8
) (
  input  logic [N-1:0][2*N-1:0] rows_i,
  output logic [2*N-1:0]        sum_o,
  output logic [2*N-1:0]        carry_o
);

  localparam int W = 2 * N;
  localparam int L = layer_count(N);

  logic [N-1:0][W-1:0] lay [L+1];

  assign lay[0] = rows_i;

  for (genvar l = 0; l < L; l++) begin : g_layer
    localparam int RIN  = rows_after(N, l);
    localparam int ROUT = rows_after(N, l + 1);
    localparam int G    = RIN / 3;

    for (genvar g = 0; g < G; g++) begin : g_grp
      logic [W-1:0] s_v;
      logic [W-2:0] c_v;
      for (genvar b = 0; b < W - 1; b++) begin : g_bit
        tree_umul_fa u_fa (
          .a_i (lay[l][3*g][b]),
          .b_i (lay[l][3*g+1][b]),
          .c_i (lay[l][3*g+2][b]),
          .s_o (s_v[b]),
          .co_o(c_v[b])
        );
      end
      // carry out of the top column would leave the 2N-bit range and is always 0
      assign s_v[W-1] = lay[l][3*g][W-1] ^ lay[l][3*g+1][W-1] ^ lay[l][3*g+2][W-1];
      assign lay[l+1][2*g]   = s_v;
      assign lay[l+1][2*g+1] = {c_v, 1'b0};
    end

    for (genvar k = 0; k < RIN % 3; k++) begin : g_pass
      assign lay[l+1][2*G+k] = lay[l][3*G+k];
    end

    for (genvar r = ROUT; r < N; r++) begin : g_zero
      assign lay[l+1][r] = '0;
    end
  end

  assign sum_o   = lay[L][0];
  assign carry_o = lay[L][1];

endmodule

// File: rtl/tree_umul_cpa.sv
module tree_umul_cpa #(
  parameter int W = 16
) (
  input  logic [W-1:0] x_i,
  input  logic [W-1:0] y_i,
  output logic [W-1:0] s_o
);

  logic [W-1:0] cy;

  assign cy[0] = 1'b0;

  for (genvar b = 0; b < W - 1; b++) begin : g_bit
    tree_umul_fa u_fa (
      .a_i (x_i[b]),
      .b_i (y_i[b]),
      .c_i (cy[b]),
      .s_o (s_o[b]),
      .co_o(cy[b+1])
    );
  end

  assign s_o[W-1] = x_i[W-1] ^ y_i[W-1] ^ cy[W-1];

endmodule

// File: rtl/tree_umul.sv
module tree_umul #(
  parameter int N = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [N-1:0]     a_i,
  input  logic [N-1:0]     b_i,
  output logic             done_o,
  output logic [2*N-1:0]   prod_o
);

  localparam int W = 2 * N;

  // reset: asserted at once, released on the clock
  logic [1:0] rsync_q;
  logic       rst_n_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end

  assign rst_n_s = rsync_q[1];

  // phase datapath
  logic [N-1:0][W-1:0] pp_rows;
  logic [N-1:0][W-1:0] rows_q, rows_d;
  logic [W-1:0]        tree_sum, tree_carry;
  logic [W-1:0]        sum_q, sum_d, carry_q, carry_d;
  logic [W-1:0]        cpa_out;
  logic [W-1:0]        prod_q, prod_d;
  logic                v1_q, v1_d, v2_q, v2_d, done_q, done_d;
  logic                acc;

  tree_umul_pp #(.N(N)) u_pp (
    .a_i   (a_i),
    .b_i   (b_i),
    .rows_o(pp_rows)
  );

  tree_umul_csa #(.N(N)) u_csa (
    .rows_i (rows_q),
    .sum_o  (tree_sum),
    .carry_o(tree_carry)
  );

  tree_umul_cpa #(.W(W)) u_cpa (
    .x_i(sum_q),
    .y_i(carry_q),
    .s_o(cpa_out)
  );

  always_comb begin
    acc     = start_i & ~v1_q & ~v2_q;
    v1_d    = acc;
    v2_d    = v1_q;
    done_d  = v2_q;
    rows_d  = acc  ? pp_rows    : rows_q;
    sum_d   = v1_q ? tree_sum   : sum_q;
    carry_d = v1_q ? tree_carry : carry_q;
    prod_d  = v2_q ? cpa_out    : prod_q;
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      v1_q    <= 1'b0;
      v2_q    <= 1'b0;
      done_q  <= 1'b0;
      rows_q  <= '0;
      sum_q   <= '0;
      carry_q <= '0;
      prod_q  <= '0;
    end else begin
      v1_q    <= v1_d;
      v2_q    <= v2_d;
      done_q  <= done_d;
      rows_q  <= rows_d;
      sum_q   <= sum_d;
      carry_q <= carry_d;
      prod_q  <= prod_d;
    end
  end

  assign done_o = done_q;
  assign prod_o = prod_q;

endmodule

// File: rtl/tree_umul_chk.sv
module tree_umul_chk #(
  parameter int N = 8
) (
  input logic           clk,
  input logic           rst_n_s,
  input logic           start_i,
  input logic [N-1:0]   a_i,
  input logic [N-1:0]   b_i,
  input logic           acc,
  input logic           v1_q,
  input logic           v2_q,
  input logic [2*N-1:0] sum_q,
  input logic [2*N-1:0] carry_q,
  input logic           done_o,
  input logic [2*N-1:0] prod_o
);

  localparam int W = 2 * N;

  // R1, R8: full-width product of the operands taken three edges earlier
  a_r1_product: assert property (@(posedge clk) disable iff (!rst_n_s)
    done_o |-> prod_o == ({{N{1'b0}}, $past(a_i, 3)} * {{N{1'b0}}, $past(b_i, 3)}));

  // R5: the two reduced rows add up to the product
  a_r5_two_rows: assert property (@(posedge clk) disable iff (!rst_n_s)
    v2_q |-> W'(sum_q + carry_q) == ({{N{1'b0}}, $past(a_i, 2)} * {{N{1'b0}}, $past(b_i, 2)}));

  // R2: a pulse only after the reduction phase held an operation
  a_r2_done_source: assert property (@(posedge clk) disable iff (!rst_n_s)
    done_o |-> $past(v2_q));

  // R2: an accepted start reaches the output on the third edge
  a_r2_latency: assert property (@(posedge clk) disable iff (!rst_n_s)
    v2_q |=> done_o);

  // R3: no start is taken while a phase is busy
  a_r3_busy_drop: assert property (@(posedge clk) disable iff (!rst_n_s)
    (start_i && (v1_q || v2_q)) |=> !v1_q);

  // R3: at most one operation in the pipe and done stage together
  a_r3_single: assert property (@(posedge clk) disable iff (!rst_n_s)
    $onehot0({v1_q, v2_q, done_o}));

  // R6: the product holds while no result completes
  a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n_s)
    !done_o |-> $stable(prod_o) || $past(!rst_n_s));

  // R3: acceptance comes only from a start request
  a_r3_accept: assert property (@(posedge clk) disable iff (!rst_n_s)
    acc |-> start_i);

endmodule

bind tree_umul tree_umul_chk #(.N(N)) u_chk (
  .clk    (clk),
  .rst_n_s(rst_n_s),
  .start_i(start_i),
  .a_i    (a_i),
  .b_i    (b_i),
  .acc    (acc),
  .v1_q   (v1_q),
  .v2_q   (v2_q),
  .sum_q  (sum_q),
  .carry_q(carry_q),
  .done_o (done_o),
  .prod_o (prod_o)
);

// File: tb/tree_umul_tb.sv
module tree_umul_tb;

  logic        clk;
  logic        rst_n;
  logic        st8, st4;
  logic [7:0]  a8, b8;
  logic [3:0]  a4, b4;
  logic        done8, done4;
  logic [15:0] p8;
  logic [7:0]  p4;

  int n_vec;
  int n_bad;

  tree_umul #(.N(8)) u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(st8), .a_i(a8), .b_i(b8),
    .done_o(done8), .prod_o(p8)
  );

  tree_umul #(.N(4)) u_dut_n4 (
    .clk(clk), .rst_n(rst_n), .start_i(st4), .a_i(a4), .b_i(b4),
    .done_o(done4), .prod_o(p4)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
  endtask

  // full 8-bit operation, with operands scrambled after the start (R9)
  task automatic op8(input logic [7:0] a, input logic [7:0] b, input string req);
    logic [15:0] exp;
    exp = {8'd0, a} * {8'd0, b};
    @(negedge clk); st8 = 1'b1; a8 = a; b8 = b;
    @(negedge clk); st8 = 1'b0; a8 = ~a; b8 = b ^ 8'h5a;
    chk(done8 == 1'b0, "R2 early", done8, 0);
    @(negedge clk);
    chk(done8 == 1'b0, "R2 early", done8, 0);
    @(negedge clk);
    chk(done8 == 1'b1, "R2 pulse", done8, 1);
    chk(p8 == exp, req, p8, exp);
    @(negedge clk);
    chk(done8 == 1'b0, "R2 width", done8, 0);
    chk(p8 == exp, "R6 hold", p8, exp);
  endtask

  task automatic op4(input logic [3:0] a, input logic [3:0] b, input string req);
    logic [7:0] exp;
    exp = {4'd0, a} * {4'd0, b};
    @(negedge clk); st4 = 1'b1; a4 = a; b4 = b;
    @(negedge clk); st4 = 1'b0; a4 = ~a; b4 = ~b;
    @(negedge clk);
    @(negedge clk);
    chk(done4 == 1'b1, "R2 n4 pulse", done4, 1);
    chk(p4 == exp, req, p4, exp);
  endtask

  task automatic t_reset();
    chk(done8 == 1'b0, "R7 done n8", done8, 0);
    chk(p8 == 16'd0, "R7 prod n8", p8, 0);
    chk(done4 == 1'b0, "R7 done n4", done4, 0);
    chk(p4 == 8'd0, "R7 prod n4", p4, 0);
  endtask

  task automatic t_example();
    op4(4'b1001, 4'b1010, "R4 worked example");
    chk(p4 == 8'b01011010, "R4 value 90", p4, 90);
  endtask

  task automatic t_exhaustive4();
    for (int i = 0; i < 16; i++)
      for (int j = 0; j < 16; j++)
        op4(4'(i), 4'(j), "R1 n4 exhaustive");
  endtask

  task automatic t_corners8();
    op8(8'hff, 8'hff, "R8 max operands");
    op8(8'h00, 8'hff, "R1 zero multiplicand");
    op8(8'hff, 8'h00, "R1 zero multiplier");
    op8(8'hb7, 8'h01, "R4 unit multiplier");
    op8(8'h80, 8'h80, "R4 top bits");
    op8(8'h55, 8'haa, "R5 alternating");
    op8(8'h01, 8'hff, "R4 unit multiplicand");
  endtask

  task automatic t_random8();
    for (int k = 0; k < 300; k++)
      op8(8'($urandom), 8'($urandom), "R1 n8 random");
  endtask

  // R3: starts during the two busy cycles are dropped
  task automatic t_ignore();
    @(negedge clk); st8 = 1'b1; a8 = 8'd200; b8 = 8'd3;
    @(negedge clk); st8 = 1'b1; a8 = 8'd7;   b8 = 8'd9;
    chk(done8 == 1'b0, "R3 no early done", done8, 0);
    @(negedge clk); st8 = 1'b1; a8 = 8'd11;  b8 = 8'd13;
    chk(done8 == 1'b0, "R3 no early done", done8, 0);
    @(negedge clk); st8 = 1'b0;
    chk(done8 == 1'b1, "R3 first result", done8, 1);
    chk(p8 == 16'd600, "R3 first product", p8, 600);
    @(negedge clk);
    chk(done8 == 1'b0, "R3 dropped start", done8, 0);
    @(negedge clk);
    @(negedge clk);
    chk(done8 == 1'b0, "R3 dropped start late", done8, 0);
    chk(p8 == 16'd600, "R6 hold after drop", p8, 600);
  endtask

  // R3: a start in the done cycle is taken
  task automatic t_back2back();
    @(negedge clk); st8 = 1'b1; a8 = 8'd17; b8 = 8'd19;
    @(negedge clk); st8 = 1'b0;
    @(negedge clk);
    @(negedge clk);
    chk(done8 == 1'b1, "R3 op A done", done8, 1);
    chk(p8 == 16'd323, "R1 op A", p8, 323);
    st8 = 1'b1; a8 = 8'd250; b8 = 8'd251;
    @(negedge clk); st8 = 1'b0;
    chk(done8 == 1'b0, "R2 gap", done8, 0);
    chk(p8 == 16'd323, "R6 hold", p8, 323);
    @(negedge clk);
    @(negedge clk);
    chk(done8 == 1'b1, "R3 op B accepted", done8, 1);
    chk(p8 == 16'd62750, "R1 op B", p8, 62750);
  endtask

  initial begin
    #2_000_000;
    n_bad++;
    $display("FAIL R2 watchdog actual=timeout expected=finish");
    summary();
    $finish;
  end

  initial begin
    n_vec = 0;
    n_bad = 0;
    rst_n = 1'b0;
    st8 = 1'b0; st4 = 1'b0;
    a8 = '0; b8 = '0; a4 = '0; b4 = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_example();
    t_exhaustive4();
    t_corners8();
    t_ignore();
    t_back2back();
    t_random8();
    repeat (2) @(negedge clk);
    summary();
    $finish;
  end

endmodule